// File: doc/BRIEF.md
# Dynamic VID Reference Sequencer

This block sits between a host's voltage-identification bus and the reference DAC of a core-voltage regulator. It reads the VID bus several times in every phase cycle. It accepts a new code only when that code has been read the same way on consecutive samples. It then moves the DAC code to the accepted value. The DAC code is an unsigned integer in 12.5 mV units, and the mapping from code to volts lies outside the block.

Two update policies are offered, chosen by a mode pin. In jump mode the DAC code takes the accepted value at once, and the host is expected to move one step at a time. In slew mode the host may move by many steps. After a half-cycle wait the block walks the DAC code toward the target by one LSB per phase cycle, up or down, and stops on the target. The first code accepted after reset is loaded directly in either mode. A one-cycle strobe marks each acceptance.

Top module: `vref_sequencer`

## Requirements
- R1: After each `tick_i` pulse the VID bus is sampled `SAMPLES` times, spaced `CYCLE_CLKS/SAMPLES` clocks apart. The first sample is taken in the tick cycle itself. For a code applied in a tick cycle and held, `vid_ok_o` rises exactly `2*CYCLE_CLKS/SAMPLES + 1` clocks after the tick cycle, with `DEBOUNCE` = 3.
- R2: `vid_ok_o` pulses high for one cycle when a value has been read on `DEBOUNCE` consecutive samples and differs from the last accepted code (or when no code has been accepted yet). The pulse comes one clock after the sample that completes the run. It never stays high for two cycles.
- R3: A value held for fewer than `DEBOUNCE` consecutive samples produces no `vid_ok_o` pulse and leaves `dac_code_o` unchanged.
- R4: The first code accepted after reset is copied to `dac_code_o` on the clock after `vid_ok_o`, whatever the mode.
- R5: With `ramp_mode_i` = 0 (jump), `dac_code_o` equals the accepted code on the clock after `vid_ok_o`, and `busy_o` is low.
- R6: With `ramp_mode_i` = 1 (slew) and no slew under way, the first DAC step appears `CYCLE_CLKS/2 + 1` clocks after the `vid_ok_o` cycle.
- R7: While slewing, `dac_code_o` moves by exactly one per step, toward the target. Steps come every `CYCLE_CLKS` clocks. The code never passes the target and stops on it.
- R8: A new code accepted during a slew replaces the target without restarting the half-cycle wait: the step cadence of `CYCLE_CLKS` clocks continues.
- R9: `busy_o` is high exactly while `dac_code_o` differs from the current target. When `busy_o` is low and no code is being accepted, `dac_code_o` holds.
- R10: In reset (synchronous, active high) and the cycle after it, `dac_code_o` = 0, `busy_o` = 0 and `vid_ok_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-clock pulse at the start of each phase cycle, every `CYCLE_CLKS` clocks |
| vid_i | input | VID_W | VID code from the host |
| ramp_mode_i | input | 1 | 0: jump to accepted code, 1: slew one LSB per phase cycle |
| dac_code_o | output | VID_W | Reference DAC code, 12.5 mV per LSB |
| busy_o | output | 1 | DAC code differs from target |
| vid_ok_o | output | 1 | One-cycle strobe on each accepted code |

## Verification
The bench builds the block with `CYCLE_CLKS` = 12, `SAMPLES` = 6, `DEBOUNCE` = 3 and `VID_W` = 8. This gives a sample spacing of 2 clocks and a half-cycle wait of 6 clocks. Debounce latency, glitch rejection and whole multi-step slews therefore fit in a few hundred clocks. The short spacing lets a two-sample glitch be placed exactly between sample points. It also lets a retarget land in the middle of a step interval, so the unbroken cadence can be measured. Slews of several steps are run both up and down, and jump mode is run with both single-step and large changes.

// File: rtl/vref_pkg.sv
package vref_pkg;
    typedef enum logic {
        MODE_JUMP = 1'b0,
        MODE_RAMP = 1'b1
    } upd_mode_e;
endpackage

// File: rtl/vref_sampler.sv
module vref_sampler #(
    parameter int VID_W      = 8,
    parameter int CYCLE_CLKS = 24,
    parameter int SAMPLES    = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [VID_W-1:0] vid_i,
    output logic             smp_stb_o,
    output logic [VID_W-1:0] smp_val_o
);
    localparam int SPACING = CYCLE_CLKS / SAMPLES;
    localparam int POS_W   = $clog2(SPACING + 1);
    localparam int IDX_W   = $clog2(SAMPLES + 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [IDX_W-1:0] idx;
        logic             stb;
        logic [VID_W-1:0] val;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (tick_i) begin
            st_d.pos = '0;
            st_d.idx = '0;
            st_d.stb = 1'b1;
            st_d.val = vid_i;
        end else if (st_q.idx < IDX_W'(SAMPLES - 1)) begin
            if (st_q.pos == POS_W'(SPACING - 1)) begin
                st_d.pos = '0;
                st_d.idx = st_q.idx + 1'b1;
                st_d.stb = 1'b1;
                st_d.val = vid_i;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.pos <= '0;
            st_q.idx <= IDX_W'(SAMPLES - 1);
            st_q.stb <= 1'b0;
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_stb_o = st_q.stb;
    assign smp_val_o = st_q.val;
endmodule

// File: rtl/vref_debounce.sv
module vref_debounce #(
    parameter int VID_W    = 8,
    parameter int DEBOUNCE = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             smp_stb_i,
    input  logic [VID_W-1:0] smp_val_i,
    output logic             acc_stb_o,
    output logic [VID_W-1:0] acc_code_o
);
    localparam int RUN_W = $clog2(DEBOUNCE + 1);

    typedef struct packed {
        logic [VID_W-1:0] cand;
        logic [RUN_W-1:0] run;
        logic [VID_W-1:0] acc;
        logic             have;
        logic             stb;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (smp_stb_i) begin
            if (smp_val_i == st_q.cand) begin
                if (st_q.run != RUN_W'(DEBOUNCE))
                    st_d.run = st_q.run + 1'b1;
            end else begin
                st_d.cand = smp_val_i;
                st_d.run  = RUN_W'(1);
            end
            if ((st_d.run == RUN_W'(DEBOUNCE)) &&
                (!st_q.have || (st_d.cand != st_q.acc))) begin
                st_d.acc  = st_d.cand;
                st_d.have = 1'b1;
                st_d.stb  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_stb_o  = st_q.stb;
    assign acc_code_o = st_q.acc;
endmodule

// File: rtl/vref_slew.sv
module vref_slew
    import vref_pkg::*;
#(
    parameter int VID_W      = 8,
    parameter int CYCLE_CLKS = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             acc_stb_i,
    input  logic [VID_W-1:0] acc_code_i,
    input  logic             ramp_mode_i,
    output logic [VID_W-1:0] dac_o,
    output logic [VID_W-1:0] tgt_o
);
    localparam int HALF  = CYCLE_CLKS / 2;
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

    typedef struct packed {
        logic [VID_W-1:0] dac;
        logic [VID_W-1:0] tgt;
        logic             init;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } slew_state_t;

    slew_state_t st_d, st_q;
    logic        jump_sel;

    assign jump_sel = !st_q.init || (upd_mode_e'(ramp_mode_i) == MODE_JUMP);

    always_comb begin
        st_d = st_q;
        // target update and start of the half-cycle wait
        if (acc_stb_i) begin
            st_d.tgt = acc_code_i;
            if (jump_sel) begin
                st_d.dac    = acc_code_i;
                st_d.init   = 1'b1;
                st_d.active = 1'b0;
            end else if (!st_q.active) begin
                st_d.active = 1'b1;
                st_d.cnt    = CNT_W'(HALF - 1);
            end
        end
        // stepping toward the newest target
        if (st_q.active && st_d.active) begin
            if (st_q.cnt == '0) begin
                if (st_q.dac < st_d.tgt)
                    st_d.dac = st_q.dac + 1'b1;
                else if (st_q.dac > st_d.tgt)
                    st_d.dac = st_q.dac - 1'b1;
                st_d.cnt = CNT_W'(CYCLE_CLKS - 1);
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (st_d.active && (st_d.dac == st_d.tgt))
            st_d.active = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_o = st_q.dac;
    assign tgt_o = st_q.tgt;
endmodule

// File: rtl/vref_sequencer.sv
module vref_sequencer #(
    parameter int VID_W      = 8,
    parameter int CYCLE_CLKS = 24,
    parameter int SAMPLES    = 6,
    parameter int DEBOUNCE   = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             ramp_mode_i,
    output logic [VID_W-1:0] dac_code_o,
    output logic             busy_o,
    output logic             vid_ok_o
);
    logic             smp_stb_w;
    logic [VID_W-1:0] smp_val_w;
    logic [VID_W-1:0] acc_code_w;
    logic [VID_W-1:0] tgt_w;

    vref_sampler #(
        .VID_W(VID_W), .CYCLE_CLKS(CYCLE_CLKS), .SAMPLES(SAMPLES)
    ) u_sampler (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .vid_i(vid_i),
        .smp_stb_o(smp_stb_w), .smp_val_o(smp_val_w)
    );

    vref_debounce #(
        .VID_W(VID_W), .DEBOUNCE(DEBOUNCE)
    ) u_debounce (
        .clk_i(clk_i), .rst_i(rst_i), .smp_stb_i(smp_stb_w), .smp_val_i(smp_val_w),
        .acc_stb_o(vid_ok_o), .acc_code_o(acc_code_w)
    );

    vref_slew #(
        .VID_W(VID_W), .CYCLE_CLKS(CYCLE_CLKS)
    ) u_slew (
        .clk_i(clk_i), .rst_i(rst_i), .acc_stb_i(vid_ok_o), .acc_code_i(acc_code_w),
        .ramp_mode_i(ramp_mode_i), .dac_o(dac_code_o), .tgt_o(tgt_w)
    );

    assign busy_o = (dac_code_o != tgt_w);
endmodule

// File: rtl/vref_seq_checker.sv
module vref_seq_checker #(
    parameter int VID_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             ramp_mode_i,
    input logic [VID_W-1:0] dac_code_o,
    input logic             busy_o,
    input logic             vid_ok_o,
    input logic             smp_stb_w,
    input logic [VID_W-1:0] acc_code_w,
    input logic [VID_W-1:0] tgt_w
);
    p_ok_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        vid_ok_o |=> !vid_ok_o);

    p_ok_after_sample_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        vid_ok_o |-> $past(smp_stb_w));

    p_jump_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (vid_ok_o && !ramp_mode_i) |=> (dac_code_o == $past(acc_code_w)));

    p_unit_step_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(vid_ok_o) |-> ((dac_code_o == $past(dac_code_o)) ||
                              (dac_code_o == $past(dac_code_o) + 1'b1) ||
                              (dac_code_o == $past(dac_code_o) - 1'b1)));

    p_no_overshoot_up_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(vid_ok_o) && $past(dac_code_o < tgt_w)) |-> (dac_code_o <= tgt_w));

    p_no_overshoot_dn_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(vid_ok_o) && $past(dac_code_o > tgt_w)) |-> (dac_code_o >= tgt_w));

    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !vid_ok_o) |=> $stable(dac_code_o));
endmodule

bind vref_sequencer vref_seq_checker #(.VID_W(VID_W)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .ramp_mode_i(ramp_mode_i),
    .dac_code_o(dac_code_o), .busy_o(busy_o), .vid_ok_o(vid_ok_o),
    .smp_stb_w(smp_stb_w), .acc_code_w(acc_code_w), .tgt_w(tgt_w)
);

// File: tb/test_vref_sequencer.sv
module test_vref_sequencer;
    localparam int VW   = 8;
    localparam int CYC  = 12;
    localparam int NSMP = 6;
    localparam int DEB  = 3;
    localparam int SP   = CYC / NSMP;
    localparam int HALF = CYC / 2;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1;
    logic          tick_i = 1'b0;
    logic [VW-1:0] vid_i = '0;
    logic          ramp_mode_i = 1'b1;
    logic [VW-1:0] dac_code_o;
    logic          busy_o;
    logic          vid_ok_o;

    always #2 clk = ~clk;

    vref_sequencer #(.VID_W(VW), .CYCLE_CLKS(CYC), .SAMPLES(NSMP), .DEBOUNCE(DEB)) i_vref_sequencer (
        .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .vid_i(vid_i),
        .ramp_mode_i(ramp_mode_i), .dac_code_o(dac_code_o), .busy_o(busy_o), .vid_ok_o(vid_ok_o)
    );

    int n_chk = 0, n_fail = 0, ncyc = 0, tph = 0, n_ok = 0;
    int last_chg = 0, last_ok = 0;
    int prev_dac = 0;
    bit done = 0;

    // behavioural reference model
    int m_pos, m_idx, m_sval, m_cand, m_run, m_acc, m_dac, m_tgt, m_cnt;
    bit m_sstb, m_have, m_ok, m_init, m_act;

    always @(posedge clk) begin
        if (rst_i) begin
            m_pos = 0; m_idx = NSMP - 1; m_sstb = 0; m_sval = 0;
            m_cand = 0; m_run = 0; m_acc = 0; m_have = 0; m_ok = 0;
            m_dac = 0; m_tgt = 0; m_init = 0; m_act = 0; m_cnt = 0;
        end else begin
            // reference update
            if (m_ok) begin
                m_tgt = m_acc;
                if (!m_init || !ramp_mode_i) begin
                    m_dac = m_acc; m_init = 1; m_act = 0;
                end else if (!m_act) begin
                    m_act = 1; m_cnt = -1;   // -1: armed this cycle
                end
            end
            if (m_act) begin
                if (m_cnt == -1) m_cnt = HALF - 1;
                else if (m_cnt == 0) begin
                    if (m_dac < m_tgt) m_dac++;
                    else if (m_dac > m_tgt) m_dac--;
                    m_cnt = CYC - 1;
                end else m_cnt--;
                if (m_dac == m_tgt) m_act = 0;
            end
            // acceptance
            m_ok = 0;
            if (m_sstb) begin
                if (m_sval == m_cand) begin
                    if (m_run < DEB) m_run++;
                end else begin
                    m_cand = m_sval; m_run = 1;
                end
                if (m_run == DEB && (!m_have || m_cand != m_acc)) begin
                    m_acc = m_cand; m_have = 1; m_ok = 1;
                end
            end
            // sampling
            m_sstb = 0;
            if (tick_i) begin
                m_pos = 0; m_idx = 0; m_sstb = 1; m_sval = int'(vid_i);
            end else if (m_idx < NSMP - 1) begin
                if (m_pos == SP - 1) begin
                    m_pos = 0; m_idx++; m_sstb = 1; m_sval = int'(vid_i);
                end else m_pos++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        ncyc++;
        if (!rst_i) begin
            check(int'(dac_code_o) == m_dac, "R7 dac_code", int'(dac_code_o), m_dac);
            check(busy_o == (m_dac != m_tgt), "R9 busy", int'(busy_o), int'(m_dac != m_tgt));
            check(vid_ok_o == m_ok, "R2 vid_ok", int'(vid_ok_o), int'(m_ok));
            if (vid_ok_o) begin n_ok++; last_ok = ncyc; end
            if (int'(dac_code_o) != prev_dac) begin last_chg = ncyc; prev_dac = int'(dac_code_o); end
        end
        tick_i = (tph == 0) && !rst_i;
        tph = (tph + 1) % CYC;
    endtask

    task automatic wait_tick();
        cyc();
        while (!tick_i) cyc();
    endtask

    task automatic wait_ok();
        cyc();
        while (!vid_ok_o) cyc();
    endtask

    task automatic wait_idle();
        cyc();
        while (busy_o) cyc();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
            report();
        end
    end

    initial begin
        int k0, okc, c0, d0;
        repeat (3) cyc();
        check(dac_code_o == 0, "R10 dac in reset", int'(dac_code_o), 0);
        check(busy_o == 0 && vid_ok_o == 0, "R10 flags in reset", int'({busy_o, vid_ok_o}), 0);
        rst_i = 1'b0;
        cyc();
        check(dac_code_o == 0 && busy_o == 0 && vid_ok_o == 0, "R10 after reset",
              int'(dac_code_o), 0);

        // first code, slew mode selected: loaded directly; debounce latency
        ramp_mode_i = 1'b1;
        wait_tick();
        vid_i = 8'h40;
        repeat (2 * SP + 1) cyc();
        check(vid_ok_o == 0, "R1 no strobe before third sample", int'(vid_ok_o), 0);
        cyc();
        check(vid_ok_o == 1, "R1 strobe after third sample", int'(vid_ok_o), 1);
        cyc();
        check(dac_code_o == 8'h40 && busy_o == 0, "R4 first code loaded", int'(dac_code_o), 8'h40);

        // slew up by six steps
        wait_tick();
        vid_i = 8'h46;
        wait_ok();
        k0 = ncyc;
        while (last_chg <= k0) cyc();
        check(ncyc - k0 == HALF + 1, "R6 first step delay", ncyc - k0, HALF + 1);
        check(dac_code_o == 8'h41, "R7 first step value", int'(dac_code_o), 8'h41);
        c0 = last_chg;
        while (last_chg == c0) cyc();
        check(last_chg - c0 == CYC, "R7 step period", last_chg - c0, CYC);
        check(dac_code_o == 8'h42, "R7 second step value", int'(dac_code_o), 8'h42);

        // retarget downward in the middle of the slew
        c0 = last_chg;
        d0 = int'(dac_code_o);
        vid_i = 8'h3D;
        wait_ok();
        while (last_chg == c0) cyc();
        check(last_chg - c0 == CYC, "R8 cadence kept on retarget", last_chg - c0, CYC);
        check(int'(dac_code_o) < d0, "R8 new direction", int'(dac_code_o), d0 - 1);
        wait_idle();
        check(dac_code_o == 8'h3D, "R7 stops on target", int'(dac_code_o), 8'h3D);
        check(busy_o == 0, "R9 idle at target", int'(busy_o), 0);

        // glitch seen on two samples only
        repeat (CYC) cyc();
        okc = n_ok;
        wait_tick();
        vid_i = 8'h50;
        repeat (SP + 1) cyc();
        vid_i = 8'h3D;
        repeat (3 * CYC) cyc();
        check(n_ok == okc, "R3 glitch gives no strobe", n_ok - okc, 0);
        check(dac_code_o == 8'h3D, "R3 glitch leaves dac", int'(dac_code_o), 8'h3D);

        // jump mode: one step, then a large step
        ramp_mode_i = 1'b0;
        vid_i = 8'h3E;
        wait_ok();
        cyc();
        check(dac_code_o == 8'h3E && busy_o == 0, "R5 jump one step", int'(dac_code_o), 8'h3E);
        vid_i = 8'h30;
        wait_ok();
        cyc();
        check(dac_code_o == 8'h30 && busy_o == 0, "R5 jump large", int'(dac_code_o), 8'h30);

        // slew down four steps
        ramp_mode_i = 1'b1;
        vid_i = 8'h2C;
        wait_ok();
        cyc();
        check(busy_o == 1, "R9 busy while waiting", int'(busy_o), 1);
        wait_idle();
        check(dac_code_o == 8'h2C, "R7 slew down end", int'(dac_code_o), 8'h2C);
        repeat (2 * CYC) cyc();
        check(dac_code_o == 8'h2C, "R9 holds when idle", int'(dac_code_o), 8'h2C);

        done = 1;
        report();
    end
endmodule